// File: doc/BRIEF.md
# Interrupt Entry Sequencer with NMI Lockout

This block sits beside an instruction sequencer and picks which pending interrupt source is entered at the next instruction boundary. Four kinds of source compete: a software interrupt request that carries its own 8-bit type, an edge-triggered non-maskable request, a single-step trap raised while the trap flag is on, and a level-sensitive maskable request whose 8-bit type comes from an external interrupt controller. When a source wins, the block emits a one-cycle service pulse with the type, a source code and the byte address of the type's entry in a vector table at address zero. Each entry is four bytes, so the address is the type times four.

The block also owns the interrupt-enable flag and the non-maskable lockout. Once a non-maskable request is entered, nothing else is entered, including a second non-maskable request, until the return-from-interrupt strobe. A non-maskable edge that arrives during lockout is held and entered after the return.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, svc_valid_o, if_o, nmi_lock_o and nmi_pend_o are all 0.
- R2: svc_addr_o equals svc_type_o multiplied by 4 (10 bits wide) whenever svc_valid_o is 1.
- R3: A rising edge on nmi_i sets nmi_pend_o on the next clock. Holding nmi_i high produces no second request. A non-maskable entry reports type 2 and source code 1.
- R4: When several sources are eligible at one boundary, the winner is software request (source code 0) first, then non-maskable (1), then trap (2), then maskable (3).
- R5: The maskable request is entered only when if_o is 1, with the type taken from intr_type_i. It is sampled only while boundary_i is 1.
- R6: Entering a non-maskable request sets nmi_lock_o. While nmi_lock_o is 1, no source of any kind is entered.
- R7: A non-maskable edge that arrives during lockout stays pending and is entered at the first boundary after iret_i clears the lockout.
- R8: Entering any interrupt clears if_o. iret_i sets if_o and clears nmi_lock_o. If both happen in one cycle, entry wins over iret_i, and iret_i wins over a flag write.
- R9: With trap_flag_i at 1 on a boundary and no higher source, a type 1 entry with source code 2 is made.
- R10: A software request is entered with its given type over the full range 0x00 to 0xFF.
- R11: svc_valid_o is a single-cycle pulse on the clock after a boundary_i cycle. Without boundary_i, no entry is made whatever the request inputs do.
- R12: if_wr_i loads if_o from if_val_i on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| swi_req_i | input | 1 | Software interrupt or exception request |
| swi_type_i | input | 8 | Type of the software request |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| trap_flag_i | input | 1 | Single-step trap flag |
| intr_i | input | 1 | Maskable request level |
| intr_type_i | input | 8 | Type supplied by the external controller |
| iret_i | input | 1 | Return-from-interrupt strobe |
| if_wr_i | input | 1 | Enable-flag write strobe |
| if_val_i | input | 1 | Value for the enable-flag write |
| svc_valid_o | output | 1 | Entry pulse |
| svc_src_o | output | 2 | Winning source code (0 sw, 1 nmi, 2 trap, 3 maskable) |
| svc_type_o | output | 8 | Entered type |
| svc_addr_o | output | 10 | Vector table byte address |
| if_o | output | 1 | Interrupt-enable flag |
| nmi_lock_o | output | 1 | Non-maskable lockout active |
| nmi_pend_o | output | 1 | Latched non-maskable edge awaiting entry |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a return strobe arrives together with a boundary while locked out. In the second, a non-maskable edge is still pending when the lockout ends. The bench provokes the first by asserting iret_i in the boundary cycle and expects no entry, because the lockout is judged on its registered value. It provokes the second by raising a fresh edge during lockout, then issuing the return, then a bare boundary, and expects a type 2 entry with the enable flag cleared again.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SRC_SWI  = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_TRAP = 2'd2,
        SRC_INTR = 2'd3
    } irq_src_e;

    localparam int NMI_TYPE  = 2;
    localparam int TRAP_TYPE = 1;

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic consume_i,
    output logic pend_o
);

    typedef struct packed {
        logic lvl;
        logic pend;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        rise;

    always_comb begin
        st_d     = st_q;
        rise     = nmi_i && !st_q.lvl;
        st_d.lvl = nmi_i;
        if (consume_i) begin
            st_d.pend = 1'b0;
        end
        if (rise) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_NMI_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (nmi_i && !st_q.lvl) |=> pend_o); // R3
    AST_NMI_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n) (!pend_o && st_q.lvl && nmi_i) |=> !pend_o); // R3

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              boundary_i,
    input  logic              lock_i,
    input  logic              if_flag_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              nmi_pend_i,
    input  logic              trap_i,
    input  logic              intr_i,
    input  logic [TYPE_W-1:0] intr_type_i,
    output logic              take_o,
    output irq_src_e          src_o,
    output logic [TYPE_W-1:0] type_o
);

    logic open_gate;
    logic intr_ok;

    always_comb begin
        open_gate = boundary_i && !lock_i;
        intr_ok   = intr_i && if_flag_i;
        take_o    = 1'b0;
        src_o     = SRC_SWI;
        type_o    = '0;
        if (open_gate) begin
            if (swi_req_i) begin
                take_o = 1'b1;
                src_o  = SRC_SWI;
                type_o = swi_type_i;
            end else if (nmi_pend_i) begin
                take_o = 1'b1;
                src_o  = SRC_NMI;
                type_o = TYPE_W'(NMI_TYPE);
            end else if (trap_i) begin
                take_o = 1'b1;
                src_o  = SRC_TRAP;
                type_o = TYPE_W'(TRAP_TYPE);
            end else if (intr_ok) begin
                take_o = 1'b1;
                src_o  = SRC_INTR;
                type_o = intr_type_i;
            end
        end
    end

endmodule

// File: rtl/vector_addr_calc.sv
module vector_addr_calc #(
    parameter int TYPE_W      = 8,
    parameter int ENTRY_BYTES = 4,
    localparam int SHIFT      = $clog2(ENTRY_BYTES),
    localparam int ADDR_W     = TYPE_W + SHIFT
) (
    input  logic [TYPE_W-1:0] type_i,
    output logic [ADDR_W-1:0] addr_o
);

    generate
        if (ENTRY_BYTES == 1) begin : g_unit
            assign addr_o = type_i;
        end else if ((1 << SHIFT) == ENTRY_BYTES) begin : g_shift
            assign addr_o = {type_i, {SHIFT{1'b0}}};
        end else begin : g_mult
            assign addr_o = ADDR_W'(type_i) * ADDR_W'(ENTRY_BYTES);
        end
    endgenerate

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int TYPE_W      = 8,
    parameter int ENTRY_BYTES = 4,
    localparam int ADDR_W     = TYPE_W + $clog2(ENTRY_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic              nmi_i,
    input  logic              trap_flag_i,
    input  logic              intr_i,
    input  logic [TYPE_W-1:0] intr_type_i,
    input  logic              iret_i,
    input  logic              if_wr_i,
    input  logic              if_val_i,
    output logic              svc_valid_o,
    output logic [1:0]        svc_src_o,
    output logic [TYPE_W-1:0] svc_type_o,
    output logic [ADDR_W-1:0] svc_addr_o,
    output logic              if_o,
    output logic              nmi_lock_o,
    output logic              nmi_pend_o
);

    typedef struct packed {
        logic              valid;
        irq_src_e          src;
        logic [TYPE_W-1:0] typ;
        logic              if_flag;
        logic              lock;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic              take;
    irq_src_e          win_src;
    logic [TYPE_W-1:0] win_type;
    logic              nmi_taken;
    logic              nmi_pend;

    nmi_edge_latch u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_i     (nmi_i),
        .consume_i (nmi_taken),
        .pend_o    (nmi_pend)
    );

    irq_arbiter #(.TYPE_W(TYPE_W)) u_arb (
        .boundary_i  (boundary_i),
        .lock_i      (st_q.lock),
        .if_flag_i   (st_q.if_flag),
        .swi_req_i   (swi_req_i),
        .swi_type_i  (swi_type_i),
        .nmi_pend_i  (nmi_pend),
        .trap_i      (trap_flag_i),
        .intr_i      (intr_i),
        .intr_type_i (intr_type_i),
        .take_o      (take),
        .src_o       (win_src),
        .type_o      (win_type)
    );

    vector_addr_calc #(.TYPE_W(TYPE_W), .ENTRY_BYTES(ENTRY_BYTES)) u_vec (
        .type_i (st_q.typ),
        .addr_o (svc_addr_o)
    );

    always_comb begin
        st_d       = st_q;
        nmi_taken  = take && (win_src == SRC_NMI);
        st_d.valid = take;
        if (take) begin
            st_d.src = win_src;
            st_d.typ = win_type;
        end
        if (nmi_taken) begin
            st_d.lock = 1'b1;
        end else if (iret_i) begin
            st_d.lock = 1'b0;
        end
        if (take) begin
            st_d.if_flag = 1'b0;
        end else if (iret_i) begin
            st_d.if_flag = 1'b1;
        end else if (if_wr_i) begin
            st_d.if_flag = if_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, src: SRC_SWI, typ: '0, if_flag: 1'b0, lock: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign svc_valid_o = st_q.valid;
    assign svc_src_o   = st_q.src;
    assign svc_type_o  = st_q.typ;
    assign if_o        = st_q.if_flag;
    assign nmi_lock_o  = st_q.lock;
    assign nmi_pend_o  = nmi_pend;

    AST_LOCK_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n) nmi_lock_o |-> !take); // R6
    AST_NMI_ENTRY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) (svc_valid_o && svc_src_o == 2'd1) |-> nmi_lock_o); // R6
    AST_NMI_TYPE_TWO: assert property (@(posedge clk) disable iff (!rst_n) (svc_valid_o && svc_src_o == 2'd1) |-> svc_type_o == TYPE_W'(NMI_TYPE)); // R3
    AST_ENTRY_CLEARS_IF: assert property (@(posedge clk) disable iff (!rst_n) svc_valid_o |-> !if_o); // R8
    AST_IRET_SETS_IF: assert property (@(posedge clk) disable iff (!rst_n) (iret_i && !take) |=> (if_o && !nmi_lock_o)); // R8
    AST_INTR_NEEDS_IF: assert property (@(posedge clk) disable iff (!rst_n) (take && win_src == SRC_INTR) |-> if_o); // R5
    AST_NO_ENTRY_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) !boundary_i |=> !svc_valid_o); // R11
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) svc_valid_o |=> !$past(svc_valid_o, 2) || !svc_valid_o || $past(boundary_i)); // R11

endmodule

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       boundary_i = 1'b0;
    logic       swi_req_i = 1'b0;
    logic [7:0] swi_type_i = '0;
    logic       nmi_i = 1'b0;
    logic       trap_flag_i = 1'b0;
    logic       intr_i = 1'b0;
    logic [7:0] intr_type_i = '0;
    logic       iret_i = 1'b0;
    logic       if_wr_i = 1'b0;
    logic       if_val_i = 1'b0;
    logic       svc_valid_o;
    logic [1:0] svc_src_o;
    logic [7:0] svc_type_o;
    logic [9:0] svc_addr_o;
    logic       if_o;
    logic       nmi_lock_o;
    logic       nmi_pend_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] t;
        logic [1:0] s;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .swi_req_i(swi_req_i), .swi_type_i(swi_type_i), .nmi_i(nmi_i),
        .trap_flag_i(trap_flag_i), .intr_i(intr_i), .intr_type_i(intr_type_i),
        .iret_i(iret_i), .if_wr_i(if_wr_i), .if_val_i(if_val_i),
        .svc_valid_o(svc_valid_o), .svc_src_o(svc_src_o), .svc_type_o(svc_type_o),
        .svc_addr_o(svc_addr_o), .if_o(if_o), .nmi_lock_o(nmi_lock_o),
        .nmi_pend_o(nmi_pend_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as entries appear.
    always @(negedge clk) begin
        if (rst_n && svc_valid_o) begin
            if (sb_q.size() == 0) begin
                chk("R11", "unexpected entry type", int'(svc_type_o), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R4", "entry source", int'(svc_src_o), int'(e.s));
                chk("R10", "entry type", int'(svc_type_o), int'(e.t));
                chk("R2", "vector address", int'(svc_addr_o), int'(e.t) * 4);
            end
        end
    end

    // Driver: one boundary cycle with the given sources.
    task automatic boundary(input string req, input bit swi, input logic [7:0] swt,
                            input bit trap, input bit intr, input logic [7:0] it,
                            input bit iret, input bit expect_entry,
                            input logic [7:0] et, input logic [1:0] es);
        @(negedge clk);
        boundary_i  = 1'b1;
        swi_req_i   = swi;
        swi_type_i  = swt;
        trap_flag_i = trap;
        intr_i      = intr;
        intr_type_i = it;
        iret_i      = iret;
        if (expect_entry) sb_q.push_back('{t: et, s: es});
        @(negedge clk);
        boundary_i  = 1'b0;
        swi_req_i   = 1'b0;
        trap_flag_i = 1'b0;
        intr_i      = 1'b0;
        iret_i      = 1'b0;
        #1;
        chk(req, "entry pulse", int'(svc_valid_o), int'(expect_entry));
    endtask

    task automatic write_if(input bit v, input bit with_iret);
        @(negedge clk);
        if_wr_i  = 1'b1;
        if_val_i = v;
        iret_i   = with_iret;
        @(negedge clk);
        if_wr_i  = 1'b0;
        iret_i   = 1'b0;
    endtask

    task automatic do_iret();
        @(negedge clk);
        iret_i = 1'b1;
        @(negedge clk);
        iret_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "valid after reset", int'(svc_valid_o), 0);
        chk("R1", "if after reset", int'(if_o), 0);
        chk("R1", "lock after reset", int'(nmi_lock_o), 0);
        chk("R1", "pend after reset", int'(nmi_pend_o), 0);

        // R5: maskable ignored while IF clear
        boundary("R5", 0, 8'h00, 0, 1, 8'h47, 0, 0, 8'h00, 2'd0);

        // R12: flag write
        write_if(1, 0);
        chk("R12", "if after write", int'(if_o), 1);

        // R5 and R8: maskable entry, IF cleared
        boundary("R5", 0, 8'h00, 0, 1, 8'h47, 0, 1, 8'h47, 2'd3);
        chk("R8", "if after entry", int'(if_o), 0);

        // R11: no boundary means no entry
        write_if(1, 0);
        @(negedge clk);
        intr_i = 1'b1; intr_type_i = 8'h20; swi_req_i = 1'b1; trap_flag_i = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk("R11", "entry without boundary", int'(svc_valid_o), 0);
        intr_i = 1'b0; swi_req_i = 1'b0; trap_flag_i = 1'b0;

        // R4 and R10: software wins, full type range
        boundary("R4", 1, 8'hFF, 1, 1, 8'h20, 0, 1, 8'hFF, 2'd0);
        write_if(1, 0);
        boundary("R10", 1, 8'h00, 0, 1, 8'h20, 0, 1, 8'h00, 2'd0);

        // R9 and R4: trap beats maskable
        write_if(1, 0);
        boundary("R9", 0, 8'h00, 1, 1, 8'h20, 0, 1, 8'h01, 2'd2);

        // R3: NMI edge latched, beats trap and maskable
        write_if(1, 0);
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); #1;
        chk("R3", "pend after edge", int'(nmi_pend_o), 1);
        nmi_i = 1'b0;
        boundary("R4", 0, 8'h00, 1, 1, 8'h20, 0, 1, 8'h02, 2'd1);
        chk("R6", "lock after nmi entry", int'(nmi_lock_o), 1);
        chk("R3", "pend consumed", int'(nmi_pend_o), 0);
        chk("R8", "if after nmi entry", int'(if_o), 0);

        // R6: everything blocked during lockout
        boundary("R6", 1, 8'h33, 0, 0, 8'h00, 0, 0, 8'h00, 2'd0);
        boundary("R6", 0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00, 2'd0);
        @(negedge clk); nmi_i = 1'b1;
        @(negedge clk); #1;
        chk("R7", "pend during lock", int'(nmi_pend_o), 1);
        boundary("R6", 0, 8'h00, 0, 0, 8'h00, 0, 0, 8'h00, 2'd0);
        // return in the boundary cycle itself: still blocked
        boundary("R6", 0, 8'h00, 0, 0, 8'h00, 1, 0, 8'h00, 2'd0);
        chk("R8", "lock cleared by iret", int'(nmi_lock_o), 0);
        chk("R8", "if set by iret", int'(if_o), 1);

        // R7: held edge entered after return
        boundary("R7", 0, 8'h00, 0, 0, 8'h00, 0, 1, 8'h02, 2'd1);
        chk("R7", "lock again", int'(nmi_lock_o), 1);

        // R3: level held high gives no second request
        do_iret();
        boundary("R3", 0, 8'h00, 0, 0, 8'h00, 0, 0, 8'h00, 2'd0);
        chk("R3", "no pend while held", int'(nmi_pend_o), 0);
        nmi_i = 1'b0;

        // R8: iret outranks a flag write of 0
        write_if(0, 1);
        chk("R8", "iret over write", int'(if_o), 1);

        repeat (2) @(negedge clk);
        chk("R11", "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule